// File: doc/BRIEF.md
# Two-Wire Synchronous Byte Shifter

This block moves one byte at a time over two pins. One pin carries a shift clock that the block makes itself. The other pin carries data in both directions. Before a transfer, software loads a byte, then picks the direction, the clock's resting level and the data timing. A one-cycle start strobe begins the transfer. The block runs eight bit periods of `DIV` system cycles each, least significant bit first, and sets a done flag when it finishes. In receive mode it samples the data pin on each rising clock edge and releases the pin for the whole byte.

Between transfers the two control inputs drive the pins directly. The clock pin shows the inverse of `clk_idle_low`, and the data pin shows `line_force`. Software can therefore toggle these inputs to make start, stop and acknowledge conditions for a two-wire bus master. The same engine also serves as a half-duplex SPI master in modes (0,0) and (1,1): the clock rests low for the first and high for the second, and in both data is sampled on the rising edge.

Within each bit period the clock is low for the first half and high for the second. The rising edge in the middle of the period is the sampling edge.

Top module: `sync_byte_shifter`

## Requirements
- R1: A transmit transfer produces exactly 8 rising clock edges. At the k-th rising edge (k = 0..7) the data pin carries bit k of the byte last written through `wr_en`/`wr_data`.
- R2: Between transfers the clock pin rests high when `clk_idle_low` is 0 and low when it is 1. During a transfer, each bit period of `DIV` cycles holds the clock low for `DIV/2` cycles and then high for `DIV/2` cycles.
- R3: With `hold_both` = 0, the data pin changes during a transfer only together with a falling clock edge. The exception is bit 0, which appears in the first cycle of the transfer. The pin never changes on a rising edge or while the clock is high.
- R4: With `hold_both` = 1, the data pin never changes in a cycle where the clock changes. Each new bit appears `DIV/4` cycles into the low half of its period, so the data is stable across both clock edges.
- R5: With `dir_rx` = 1 at start, `sda_oe` is 0 for the whole transfer. The value of `sda_i` at each rising edge is stored LSB first, and `rd_data` equals the received byte once `done` is set. With `dir_rx` = 0, `sda_oe` stays 1.
- R6: `done` rises exactly `8*DIV` cycles after the cycle in which a start is accepted. It is cleared in the cycle after the next accepted start.
- R7: A start strobe issued during a transfer is ignored and does not lengthen or restart the transfer.
- R8: While no transfer runs, `sclk_o` follows `!clk_idle_low` and `sda_o` follows `line_force` with `sda_oe` = 1, within the same cycle.
- R9: During a transfer, changes to `clk_idle_low`, `line_force`, `dir_rx`, `hold_both` and `wr_en`/`wr_data` have no effect on the clock, the data sent or the received byte. Direction and timing mode are captured at start.
- R10: After reset, `done` is 0, `rd_data` is 0x00, `sda_oe` is 1, and the pins show the forcing levels described in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load `wr_data` as the byte to send (ignored while shifting) |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| start | input | 1 | One-cycle strobe that begins a transfer |
| dir_rx | input | 1 | 1 = receive, 0 = transmit (captured at start) |
| clk_idle_low | input | 1 | 1 = clock rests low, 0 = clock rests high; forces the clock pin while idle |
| hold_both | input | 1 | 1 = data stable across both clock edges (captured at start) |
| line_force | input | 1 | Level forced on the data pin while idle |
| done | output | 1 | Set when a transfer completes |
| sclk_o | output | 1 | Shift clock pin |
| sda_o | output | 1 | Data pin output value |
| sda_oe | output | 1 | Data pin output enable |
| sda_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with `DIV` = 8. Each half bit period is then four cycles, and the hold-mode data change falls two cycles into the low half, two cycles away from either clock edge. A change that drifts onto an edge, or a half period that is one cycle short, therefore shows up as a separate sampled event. Transfers cover both clock resting levels, both timing modes and both directions. Several of them push every control input, a write and a second start into the middle of the transfer.

// File: rtl/sync_byte_shifter.sv
module sync_byte_shifter #(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       start,
  input  logic       dir_rx,
  input  logic       clk_idle_low,
  input  logic       hold_both,
  input  logic       line_force,
  output logic       done,
  output logic       sclk_o,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic       sda_i
);
  localparam int CW = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam int QTR = DIV / 4;

  logic          busy, rx_l, hold_l, dout;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    txb, rxb;
  logic          last_ph;

  assign last_ph = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      rx_l   <= 1'b0;
      hold_l <= 1'b0;
      dout   <= 1'b1;
      cnt    <= '0;
      bidx   <= '0;
      txb    <= '0;
      rxb    <= '0;
    end else if (!busy) begin
      if (wr_en) txb <= wr_data;
      if (start) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        cnt    <= '0;
        bidx   <= '0;
        rx_l   <= dir_rx;
        hold_l <= hold_both;
        dout   <= hold_both ? line_force : (wr_en ? wr_data[0] : txb[0]);
      end
    end else begin
      cnt <= last_ph ? '0 : cnt + CW'(1);
      if (rx_l && cnt == CW'(HALF - 1)) rxb[bidx] <= sda_i;
      if (hold_l && cnt == CW'(QTR - 1)) dout <= txb[bidx];
      if (last_ph) begin
        if (bidx == 3'd7) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bidx <= bidx + 3'd1;
          if (!hold_l) dout <= txb[bidx + 3'd1];
        end
      end
    end
  end

  assign sclk_o  = busy ? (cnt >= CW'(HALF)) : ~clk_idle_low;
  assign sda_o   = busy ? dout : line_force;
  assign sda_oe  = ~(busy & rx_l);
  assign rd_data = rxb;
endmodule

// File: rtl/sync_byte_shifter_chk.sv
module sync_byte_shifter_chk #(
  parameter int DIV = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic dir_rx,
  input logic busy,
  input logic hold_l,
  input logic done,
  input logic sclk_o,
  input logic sda_o,
  input logic sda_oe
);
  logic [31:0] len;

  always_ff @(posedge clk) begin
    if (!rst_n) len <= '0;
    else len <= busy ? len + 32'd1 : 32'd0;
  end

  AST_FALL_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !hold_l && (sda_o != $past(sda_o))) |-> $fell(sclk_o)); // R3

  AST_HOLD_STABLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && hold_l && (sclk_o != $past(sclk_o))) |-> $stable(sda_o)); // R4

  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (sda_oe == !$past(dir_rx))); // R5

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R6

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6

  AST_XFER_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len == 32'(8 * DIV))); // R7
endmodule

bind sync_byte_shifter sync_byte_shifter_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx), .busy(busy),
  .hold_l(hold_l), .done(done), .sclk_o(sclk_o), .sda_o(sda_o), .sda_oe(sda_oe)
);

// File: tb/tb_sync_byte_shifter.sv
`timescale 1ns/1ps
module tb_sync_byte_shifter;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, dir_rx = 1'b0;
  logic clk_idle_low = 1'b0, hold_both = 1'b0, line_force = 1'b1;
  logic [7:0] wr_data = '0, rd_data, rxpat = '0;
  logic done, sclk_o, sda_o, sda_oe, sda_i;

  int checks = 0, fails = 0;
  logic mon_clr = 1'b0, inx = 1'b0, cur_rx = 1'b0;
  int rises, chg_rise, chg_fall, chg_high, oebad, lowc, highc;
  logic [7:0] cap;
  logic psclk = 1'b1, psda = 1'b1;

  always #4 clk = ~clk;

  sync_byte_shifter #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .start(start), .dir_rx(dir_rx), .clk_idle_low(clk_idle_low), .hold_both(hold_both),
    .line_force(line_force), .done(done), .sclk_o(sclk_o), .sda_o(sda_o),
    .sda_oe(sda_oe), .sda_i(sda_i)
  );

  assign sda_i = (rises < 8) ? rxpat[rises[2:0]] : 1'b1;

  always @(negedge clk) begin
    if (mon_clr) begin
      rises = 0; chg_rise = 0; chg_fall = 0; chg_high = 0;
      oebad = 0; lowc = 0; highc = 0; cap = '0;
    end else if (inx) begin
      if (sclk_o && !psclk && rises < 8) begin
        cap[rises[2:0]] = sda_o;
        rises++;
      end
      if (sda_o !== psda) begin
        if (sclk_o !== psclk) begin
          if (psclk) chg_fall++;
          else chg_rise++;
        end else if (sclk_o) chg_high++;
      end
      if (sda_oe !== !cur_rx) oebad++;
      if (sclk_o) highc++;
      else lowc++;
    end
    psclk = sclk_o;
    psda = sda_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R10 done", done, 0);
    check(rd_data == 8'h00, "R10 rd_data", rd_data, 0);
    check(sda_oe == 1'b1, "R10 sda_oe", sda_oe, 1);
    check(sclk_o == 1'b1, "R10 sclk idle", sclk_o, 1);
    check(sda_o == 1'b1, "R10 sda idle", sda_o, 1);
  endtask

  task automatic t_force();
    @(posedge clk); #1 clk_idle_low = 1'b1;
    #1 check(sclk_o == 1'b0, "R8 clock forced low", sclk_o, 0);
    clk_idle_low = 1'b0;
    #1 check(sclk_o == 1'b1, "R8 clock forced high", sclk_o, 1);
    line_force = 1'b0;
    #1 check(sda_o == 1'b0 && sda_oe == 1'b1, "R8 data forced low", {sda_oe, sda_o}, 2);
    line_force = 1'b1;
    #1 check(sda_o == 1'b1, "R8 data forced high", sda_o, 1);
  endtask

  task automatic t_xfer(input logic [7:0] b, input logic rx, input logic hold,
                        input logic isel, input bit disturb);
    int n;
    @(posedge clk); #1;
    clk_idle_low = isel; line_force = 1'b1; dir_rx = rx; hold_both = hold;
    wr_en = 1'b1; wr_data = b; rxpat = b; cur_rx = rx; mon_clr = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; mon_clr = 1'b0;
    check(sclk_o == !isel, "R2 idle level before start", sclk_o, !isel);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; inx = 1'b1;
    check(done == 1'b0, "R6 done cleared by start", done, 0);
    n = 0;
    while (!done && n < 4000) begin
      @(posedge clk); #1;
      n++;
      if (disturb && n == 20) begin
        start = 1'b1; clk_idle_low = !isel; line_force = 1'b0;
        dir_rx = !rx; hold_both = !hold; wr_en = 1'b1; wr_data = ~b;
      end
      if (disturb && n == 21) begin
        start = 1'b0; clk_idle_low = isel; line_force = 1'b1;
        dir_rx = rx; hold_both = hold; wr_en = 1'b0;
      end
    end
    inx = 1'b0;
    check(n == 8 * DIV, disturb ? "R7 length with start while busy" : "R6 done timing", n, 8 * DIV);
    check(rises == 8, "R1 rising edge count", rises, 8);
    if (rx) check(rd_data == b, disturb ? "R9 received byte" : "R5 received byte", rd_data, b);
    else check(cap == b, disturb ? "R9 sent byte" : "R1 sent byte", cap, b);
    check(oebad == 0, "R5 output enable during transfer", oebad, 0);
    check(lowc == 4 * DIV && highc == 4 * DIV, "R2 clock halves", lowc, 4 * DIV);
    check(chg_rise == 0 && chg_high == 0, hold ? "R4 change on rise or high" : "R3 change on rise or high",
          chg_rise + chg_high, 0);
    if (hold) check(chg_fall == 0, "R4 change on falling edge", chg_fall, 0);
    #1 check(sclk_o == !isel && sda_o == 1'b1, "R8 lines back to forced levels", {sclk_o, sda_o}, {!isel, 1'b1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_force();
    t_xfer(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    t_xfer(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0);
    t_xfer(8'h96, 1'b1, 1'b0, 1'b0, 1'b0);
    t_xfer(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0);
    t_xfer(8'hC3, 1'b0, 1'b0, 1'b1, 1'b1);
    t_xfer(8'h81, 1'b0, 1'b1, 1'b0, 1'b1);
    t_xfer(8'h7E, 1'b1, 1'b0, 1'b1, 1'b1);
    t_force();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule